// File: doc/BRIEF.md
# Byte-Wide Many-Time-Programmable Memory Controller

This block is the control logic of a small byte-wide nonvolatile memory model with a parameterised storage array. Software does not drive it. An external programmer drives it through active-low chip-enable, output-enable and write-enable lines, an address bus, and an 8-bit data bus. The data bus is split into an input byte, an output byte and an output-enable.

The block does not use command sequences. Two digital flags select its special modes. One flag reports a high voltage on the output-enable line and the other reports a high voltage on address bit 9. With neither flag set, the block reads bytes or leaves the bus undriven. The address-bit-9 flag alone gives the manufacturer and device identifiers. The output-enable flag alone allows byte programming. Both flags together allow a whole-array erase.

Programming and erase are timed with clock-cycle counters, and a busy output stays high while either one runs. Programming can only clear bits, so only an erase can return a bit to 1. If a required flag drops while an operation is running, the operation is abandoned and a sticky error flag is raised.

Top module: `mtp_byte_ctrl`

## Requirements
- R1: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0 and `oe_hv`=0. In every other case `dq_oe` is 0, so the bus is undriven.
- R2: While `ce_n`=1 the block is in standby: `dq_oe` is 0 and no write-enable pulse starts an operation.
- R3: In read mode (`ce_n`=0, `oe_n`=0, `we_n`=1, both flags 0), `dq_o` shows the stored byte at `addr` in the same cycle. After reset every stored byte is 0xFF.
- R4: Identification mode is `a9_hv`=1, `oe_hv`=0, `ce_n`=0, `oe_n`=0 and `we_n`=1. In this mode `dq_o` is 0xBF when `addr[0]`=0. When `addr[0]`=1, `dq_o` is the device identifier: 0xC5, 0xC6 or 0xC2 for `SIZE_SEL` 0, 1 or 2.
- R5: A program starts on the first clock edge that samples `we_n`=0 after `we_n`=1, with `ce_n`=0, `oe_hv`=1 and `a9_hv`=0. That edge latches `addr` and `dq_i`. `busy` then stays high for exactly `PROG_CYC` cycles. When it ends, the stored byte becomes old AND new, so a 1 never overwrites a 0.
- R6: An erase starts on the same kind of `we_n` falling sample with `ce_n`=0, `oe_hv`=1 and `a9_hv`=1. `addr` and `dq_i` are ignored. `busy` stays high for exactly `ERASE_CYC` cycles, and then every byte reads 0xFF.
- R7: A `we_n` falling sample with `oe_hv`=0 starts nothing: `busy` stays 0 and no stored byte changes.
- R8: A `we_n` falling sample while `busy`=1 is ignored: neither its address nor its data reaches the array.
- R9: While `busy`=1, the operation aborts if `oe_hv` drops (program or erase) or `a9_hv` drops (erase). `busy` clears on the next edge, `err` becomes 1, and the array is unchanged. `err` is cleared by reset or by the start of the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; its falling sample starts operations |
| oe_hv | input | 1 | High-voltage flag on the output-enable line |
| a9_hv | input | 1 | High-voltage flag on address bit 9 |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data bus input byte |
| dq_o | output | 8 | Data bus output byte |
| dq_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Sticky abort flag |

## Verification
The bench builds the block with `ADDR_W`=10, `SIZE_SEL`=1, `PROG_CYC`=6 and `ERASE_CYC`=20. With these values the full 1024-byte array can be programmed and read back twice with arithmetic patterns. That shows the AND behaviour at every address and every bit. The short cycle counts let the bench measure busy windows exactly and run aborts partway through both operation kinds well inside the run limit. With `SIZE_SEL`=1 the device identifier is 0xC6, which differs from both neighbouring settings.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_DISABLE,
        MD_READ,
        MD_IDENT,
        MD_PROGRAM,
        MD_ERASE
    } mode_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE
    } op_kind_t;

    localparam logic [7:0] MFR_CODE  = 8'hBF;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    function automatic logic [7:0] dev_code(input int sel);
        case (sel)
            0:       dev_code = 8'hC5;
            1:       dev_code = 8'hC6;
            default: dev_code = 8'hC2;
        endcase
    endfunction

endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
    import mtp_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  we_n,
    input  logic  oe_hv,
    input  logic  a9_hv,
    output mode_t mode
);
    always_comb begin
        if (ce_n)
            mode = MD_STANDBY;
        else if (oe_hv && a9_hv)
            mode = MD_ERASE;
        else if (oe_hv)
            mode = MD_PROGRAM;
        else if (!oe_n && we_n && a9_hv)
            mode = MD_IDENT;
        else if (!oe_n && we_n)
            mode = MD_READ;
        else
            mode = MD_DISABLE;
    end
endmodule

// File: rtl/mtp_op_timer.sv
module mtp_op_timer
    import mtp_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PROG_CYC  = 1500,
    parameter int ERASE_CYC = 10000000
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_i,
    output logic              busy,
    output logic              err,
    output logic              prog_fire,
    output logic              erase_fire,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

    logic           we_q;
    logic           we_fall;
    logic [CNT_W-1:0] cnt;
    op_kind_t       kind;
    logic           abort;

    assign we_fall = we_q && !we_n;

    always_comb begin
        case (kind)
            OP_PROG:  abort = !oe_hv;
            OP_ERASE: abort = !oe_hv || !a9_hv;
            default:  abort = 1'b0;
        endcase
    end

    assign prog_fire  = busy && !abort && (cnt == '0) && (kind == OP_PROG);
    assign erase_fire = busy && !abort && (cnt == '0) && (kind == OP_ERASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b1;
            busy    <= 1'b0;
            err     <= 1'b0;
            cnt     <= '0;
            kind    <= OP_NONE;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            we_q <= we_n;
            if (busy) begin
                if (abort) begin
                    busy <= 1'b0;
                    err  <= 1'b1;
                    kind <= OP_NONE;
                end else if (cnt == '0) begin
                    busy <= 1'b0;
                    kind <= OP_NONE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (we_fall && mode == MD_PROGRAM) begin
                busy    <= 1'b1;
                err     <= 1'b0;
                kind    <= OP_PROG;
                cnt     <= PROG_LOAD;
                op_addr <= addr;
                op_data <= dq_i;
            end else if (we_fall && mode == MD_ERASE) begin
                busy <= 1'b1;
                err  <= 1'b0;
                kind <= OP_ERASE;
                cnt  <= ERASE_LOAD;
            end
        end
    end
endmodule

// File: rtl/mtp_cell_array.sv
module mtp_cell_array
    import mtp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_fire,
    input  logic              erase_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst || erase_fire)
                cells[g] <= BLANK_BYTE;
            else if (prog_fire && wr_addr == ADDR_W'(g))
                cells[g] <= cells[g] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/mtp_byte_ctrl.sv
module mtp_byte_ctrl
    import mtp_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int SIZE_SEL  = 0,
    parameter int PROG_CYC  = 1500,
    parameter int ERASE_CYC = 10000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_i,
    output logic [7:0]        dq_o,
    output logic              dq_oe,
    output logic              busy,
    output logic              err
);
    localparam logic [7:0] DEV_ID = dev_code(SIZE_SEL);

    mode_t             mode;
    logic              prog_fire;
    logic              erase_fire;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;
    logic [7:0]        rd_data;

    mtp_mode_decode u_dec (
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .oe_hv (oe_hv),
        .a9_hv (a9_hv),
        .mode  (mode)
    );

    mtp_op_timer #(
        .ADDR_W    (ADDR_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .we_n       (we_n),
        .oe_hv      (oe_hv),
        .a9_hv      (a9_hv),
        .addr       (addr),
        .dq_i       (dq_i),
        .busy       (busy),
        .err        (err),
        .prog_fire  (prog_fire),
        .erase_fire (erase_fire),
        .op_addr    (op_addr),
        .op_data    (op_data)
    );

    mtp_cell_array #(
        .ADDR_W (ADDR_W)
    ) u_arr (
        .clk        (clk),
        .rst        (rst),
        .prog_fire  (prog_fire),
        .erase_fire (erase_fire),
        .wr_addr    (op_addr),
        .wr_data    (op_data),
        .rd_addr    (addr),
        .rd_data    (rd_data)
    );

    always_comb begin
        dq_oe = (mode == MD_READ) || (mode == MD_IDENT);
        if (mode == MD_IDENT)
            dq_o = addr[0] ? DEV_ID : MFR_CODE;
        else
            dq_o = rd_data;
    end
endmodule

// File: rtl/mtp_byte_ctrl_chk.sv
module mtp_byte_ctrl_chk #(
    parameter int ADDR_W   = 10,
    parameter int SIZE_SEL = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              oe_hv,
    input logic              a9_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dq_i,
    input logic [7:0]        dq_o,
    input logic              dq_oe,
    input logic              busy,
    input logic              err
);
    localparam logic [7:0] ID_EXP = (SIZE_SEL == 0) ? 8'hC5 :
                                    (SIZE_SEL == 1) ? 8'hC6 : 8'hC2;

    p_drive_gate_r1: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!ce_n && !oe_n && !oe_hv));

    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !busy) |=> (!busy && !dq_oe) || !ce_n);

    p_ident_bytes_r4: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && we_n && a9_hv && !oe_hv) |->
            (dq_o == (addr[0] ? ID_EXP : 8'hBF)));

    p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ce_n && oe_hv && !we_n && $past(we_n)) |=> busy);

    p_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !oe_hv) |=> !busy);

    p_abort_err_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !oe_hv) |=> (!busy && err));

endmodule

bind mtp_byte_ctrl mtp_byte_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .SIZE_SEL (SIZE_SEL)
) u_chk (.*);

// File: tb/mtp_byte_ctrl_tb.sv
module mtp_byte_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PROG_CYC   = 6;
    localparam int ERASE_CYC  = 20;

    logic              clk = 1'b0;
    logic              rst;
    logic              ce_n, oe_n, we_n, oe_hv, a9_hv;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        dq_i;
    logic [7:0]        dq_o;
    logic              dq_oe, busy, err;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    mtp_byte_ctrl #(
        .ADDR_W    (ADDR_W),
        .SIZE_SEL  (1),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_dut (
        .clk   (clk),
        .rst   (rst),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .oe_hv (oe_hv),
        .a9_hv (a9_hv),
        .addr  (addr),
        .dq_i  (dq_i),
        .dq_o  (dq_o),
        .dq_oe (dq_oe),
        .busy  (busy),
        .err   (err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0;
    endtask

    task automatic read_at(input int a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0;
        addr = ADDR_W'(a);
        #1;
        d = dq_o; oe = dq_oe;
    endtask

    // Starts an operation; returns on the negedge after the start edge.
    task automatic start_op(input int a, input logic [7:0] d, input logic erase);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b1; a9_hv = erase;
        addr = ADDR_W'(a); dq_i = d;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sweep_check(input string req);
        int bad = 0;
        logic [7:0] d;
        logic oe;
        for (int a = 0; a < DEPTH; a++) begin
            read_at(a, d, oe);
            if (d !== model[a] || oe !== 1'b1) begin
                bad++;
                if (bad < 4)
                    $display("FAIL %s addr=%0d actual=%0h expected=%0h", req, a, d, model[a]);
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        logic [7:0] d;
        logic oe;
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0;
        addr = '0; dq_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R2 standby drive", dq_oe, 0);
        check("R9 err after reset", err, 0);
        check("R5 busy after reset", busy, 0);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;

        // R3: blank array after reset, R1 driven in read
        sweep_check("R3 blank read");
        read_at(5, d, oe);
        check("R1 read drives", oe, 1);
        @(negedge clk); oe_n = 1'b1; #1;
        check("R1 oe_n high undriven", dq_oe, 0);
        @(negedge clk); oe_n = 1'b0; oe_hv = 1'b1; #1;
        check("R1 oe_hv undriven", dq_oe, 0);
        @(negedge clk); oe_hv = 1'b0; ce_n = 1'b1; #1;
        check("R2 ce_n high undriven", dq_oe, 0);

        // R4: identification bytes
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; a9_hv = 1'b1; oe_hv = 1'b0;
        addr = 10'h2A4; #1;
        check("R4 manufacturer id", dq_o, 8'hBF);
        check("R4 ident drives", dq_oe, 1);
        @(negedge clk); addr = 10'h001; #1;
        check("R4 device id", dq_o, 8'hC6);
        idle();

        // R5: busy window length
        start_op(0, 8'hF0, 1'b0);
        wait_done(n);
        check("R5 program busy cycles", n, PROG_CYC);
        model[0] = model[0] & 8'hF0;

        // R5: program whole array, pattern one
        for (int a = 1; a < DEPTH; a++) begin
            start_op(a, 8'((a * 37 + 5) ^ (a >> 3)), 1'b0);
            wait_done(n);
            model[a] = model[a] & 8'((a * 37 + 5) ^ (a >> 3));
        end
        sweep_check("R5 program pattern one");
        // R5: second pass, 1s never restore 0s
        for (int a = 0; a < DEPTH; a++) begin
            start_op(a, 8'(a ^ 8'h5A) | 8'h81, 1'b0);
            wait_done(n);
            model[a] = model[a] & (8'(a ^ 8'h5A) | 8'h81);
        end
        sweep_check("R5 program and-merge");

        // R7: write pulse without oe_hv
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0; addr = 10'd3; dq_i = 8'h00;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        check("R7 inhibit busy", busy, 0);
        read_at(3, d, oe);
        check("R7 inhibit data", d, model[3]);

        // R2: pulse while deselected
        @(negedge clk); ce_n = 1'b1; oe_hv = 1'b1; addr = 10'd4; dq_i = 8'h00;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        check("R2 standby no start", busy, 0);
        read_at(4, d, oe);
        check("R2 standby data", d, model[4]);

        // R8: second pulse during busy
        start_op(7, 8'h00, 1'b0);
        addr = 10'd8; dq_i = 8'h00;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        wait_done(n);
        model[7] = 8'h00;
        read_at(7, d, oe);
        check("R8 first op applied", d, 8'h00);
        read_at(8, d, oe);
        check("R8 pulse in busy ignored", d, model[8]);

        // R9: program abort
        start_op(9, 8'h00, 1'b0);
        @(negedge clk); oe_hv = 1'b0;
        @(negedge clk);
        check("R9 program abort busy", busy, 0);
        check("R9 program abort err", err, 1);
        read_at(9, d, oe);
        check("R9 program abort data", d, model[9]);

        // R9: erase abort via a9 flag
        start_op(0, 8'h00, 1'b1);
        check("R9 err cleared on start", err, 0);
        @(negedge clk); @(negedge clk); a9_hv = 1'b0;
        @(negedge clk);
        check("R9 erase abort busy", busy, 0);
        check("R9 erase abort err", err, 1);
        read_at(7, d, oe);
        check("R9 erase abort data", d, 8'h00);

        // R6: full erase, address and data ignored
        start_op(10'h155, 8'h00, 1'b1);
        wait_done(n);
        check("R6 erase busy cycles", n, ERASE_CYC);
        check("R6 erase no err", err, 0);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        sweep_check("R6 erase to ones");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule